// File: doc/BRIEF.md
# Chained-Descriptor DMA Engine

This block is the internal DMA engine of a storage-card host controller. Software builds a list of four-word descriptors in memory and hands each one to the engine by setting its ownership bit. It then writes the address of the first descriptor into the base register and sets the run bit. The engine walks the list. For each descriptor it moves the described buffer between memory and the host's data FIFO, one word per memory access. It then returns the descriptor to software by writing the flag word back with the ownership bit cleared, and follows the link to the next descriptor.

Transmit (`dir_rx_i` low) reads buffer words from memory and pushes them into the FIFO. Receive (`dir_rx_i` high) pops FIFO words and writes them to memory. The direction is latched when a run starts. Completion and error events are kept as sticky status bits. Each status bit can be routed to a single interrupt line through enable bits.

Descriptor layout, in 32-bit words at byte offsets 0/4/8/12:
- word 0 holds the flags: bit 31 owned-by-engine, bit 1 no-completion-interrupt, bit 2 final, bit 3 transfer-start, bit 4 linked, bit 5 wrap.
- word 1 bits [15:0] hold the byte count.
- word 2 holds the word-aligned buffer address.
- word 3 holds the link address.

Register map, selected by `reg_addr_i`:
- 0 is control: bit 0 soft reset (write only), bit 1 fixed burst, bit 2 run/busy.
- 1 is the descriptor base address.
- 2 is interrupt enable: bit 0 tx, bit 1 rx, bit 2 bus error, bit 4 bad descriptor.
- 3 is status.

Top module: `desc_dma`

## Requirements
- R1: Writing control with bit 2 set (bit 0 clear) while idle starts a run whose first memory access is a read of word 0 of the descriptor at the base register address. Control bit 1 (fixed burst) reads back as written and drives `mem_fixburst_o`, and the base register reads back as written.
- R2: If a fetched word 0 has bit 31 clear, the engine stops without touching any buffer or writing back. It sets status bit 4 (bad descriptor) and bit 5 (error summary).
- R3: The buffer length is word 1 bits [15:0] in bytes. It is moved as ceil(bytes/4) words, and a value of 0 moves 65536 bytes (16384 words).
- R4: In transmit, buffer words are read at ascending addresses from word 2 and pushed into the FIFO in that order. In receive, popped FIFO words are written at ascending addresses in pop order, with no word lost or repeated.
- R5: After a buffer completes, word 0 of its descriptor is written back with bit 31 cleared and all other bits unchanged.
- R6: The next descriptor is found as follows. If word 0 bit 4 is set, it is at the word 3 address. If bit 4 is clear and bit 5 is set, it is at the base register address. Otherwise it is at the current descriptor address plus 16.
- R7: A descriptor with word 0 bit 2 set ends the run after its write-back. Control bit 2 reads 1 while a run is active and 0 once it has ended.
- R8: On write-back of a descriptor with word 0 bit 1 clear, status bit 0 (transmit) or bit 1 (receive) is set. With bit 1 set, no completion status is raised.
- R9: Status bit 8 is the OR of status bits 0 and 1 masked by enable bits 0 and 1. Bit 9 is the OR of status bits 2 and 4 masked by enable bits 2 and 4. Bit 5 is the unmasked OR of bits 2 and 4. `irq_o` equals bit 8 OR bit 9.
- R10: Writing the status register clears each of bits 0, 1, 2 and 4 where the written value has a 1, and leaves the bits written with 0 unchanged.
- R11: A memory access completed with `mem_err_i` high stops the run at once, with no write-back and no FIFO transfer for that word. It sets status bit 2 (bus error) and bit 5.
- R12: Writing control with bit 0 set returns the engine to idle on the next cycle and clears the fixed-burst bit and all status. The base and enable registers are kept.
- R13: No transmit buffer read is requested while `fifo_full_i` is high, and no receive buffer write is requested while `fifo_empty_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| dir_rx_i | input | 1 | Direction for the next run: 1 FIFO to memory, 0 memory to FIFO |
| mem_req_o | output | 1 | Memory access request, held until `mem_valid_i` |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, qualified by `mem_valid_i` |
| mem_valid_i | input | 1 | Access completes this cycle |
| mem_err_i | input | 1 | Completing access failed |
| mem_fixburst_o | output | 1 | Fixed-burst hint from control bit 1 |
| fifo_push_o | output | 1 | Push `fifo_wdata_o` into the FIFO |
| fifo_wdata_o | output | DW | Word pushed toward the card |
| fifo_full_i | input | 1 | FIFO cannot accept a word |
| fifo_pop_o | output | 1 | Remove the head word of the FIFO |
| fifo_rdata_i | input | DW | Head word of the FIFO (show-ahead) |
| fifo_empty_i | input | 1 | FIFO holds no word |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions assume a one-outstanding memory port: `mem_valid_i` only comes while a request is up. They also assume that `fifo_full_i` can only rise through the engine's own pushes and `fifo_empty_i` only through its own pops. Under those conditions a request, once raised, stays raised with a stable address until it completes. The bench memory answers one cycle after each request. Its FIFO models derive full from an occupancy count that only the drain lowers, and empty from read and write pointers where only the engine moves the read side. Register writes happen only at the control points listed in the requirements, so the other inputs keep to those conditions throughout.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  // descriptor word 0 flag positions
  localparam int OWN_B   = 31;
  localparam int NOIRQ_B = 1;
  localparam int LAST_B  = 2;
  localparam int FIRST_B = 3;
  localparam int CHAIN_B = 4;
  localparam int RING_B  = 5;
  // status bit positions
  localparam int S_TX  = 0;
  localparam int S_RX  = 1;
  localparam int S_BUS = 2;
  localparam int S_BAD = 4;
  localparam int S_ERR = 5;
  localparam int S_NRM = 8;
  localparam int S_ABN = 9;
  // register select
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_BASE = 2'd1;
  localparam logic [1:0] A_IE   = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  // control bits
  localparam int C_SRST = 0;
  localparam int C_FIXB = 1;
  localparam int C_RUN  = 2;

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_MOVE, W_WBACK} walk_e;

  typedef struct packed {
    logic bad_desc;
    logic bus_err;
    logic rx_done;
    logic tx_done;
  } evt_t;
endpackage

// File: rtl/dma_csr.sv
module dma_csr
  import desc_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  input  logic          busy_i,
  input  evt_t          evt_i,
  output logic          start_o,
  output logic          srst_o,
  output logic [AW-1:0] base_o,
  output logic          fixb_o,
  output logic          irq_o
);
  logic          fixb_q;
  logic [AW-1:0] base_q;
  logic [3:0]    ie_q, st_q, clr, ev;   // order: bad, bus, rx, tx
  logic          wr_ctrl, wr_stat, nrm, abn;
  logic [RW-1:0] stat_full, ie_full;

  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);
  assign srst_o  = wr_ctrl && reg_wdata_i[C_SRST];
  assign start_o = wr_ctrl && reg_wdata_i[C_RUN] && !reg_wdata_i[C_SRST] && !busy_i;
  assign ev      = evt_i;
  assign clr     = wr_stat ? {reg_wdata_i[S_BAD], reg_wdata_i[S_BUS],
                              reg_wdata_i[S_RX], reg_wdata_i[S_TX]} : 4'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fixb_q <= 1'b0;
      base_q <= '0;
      ie_q   <= '0;
      st_q   <= '0;
    end else if (srst_o) begin
      fixb_q <= 1'b0;
      st_q   <= '0;
    end else begin
      if (wr_ctrl) fixb_q <= reg_wdata_i[C_FIXB];
      if (reg_we_i && reg_addr_i == A_BASE) base_q <= reg_wdata_i[AW-1:0];
      if (reg_we_i && reg_addr_i == A_IE)
        ie_q <= {reg_wdata_i[S_BAD], reg_wdata_i[S_BUS], reg_wdata_i[S_RX], reg_wdata_i[S_TX]};
      st_q <= (st_q & ~clr) | ev;   // set wins over clear
    end
  end

  assign nrm = |(st_q[1:0] & ie_q[1:0]);
  assign abn = |(st_q[3:2] & ie_q[3:2]);

  always_comb begin
    stat_full        = '0;
    stat_full[S_TX]  = st_q[0];
    stat_full[S_RX]  = st_q[1];
    stat_full[S_BUS] = st_q[2];
    stat_full[S_BAD] = st_q[3];
    stat_full[S_ERR] = st_q[2] | st_q[3];
    stat_full[S_NRM] = nrm;
    stat_full[S_ABN] = abn;
    ie_full          = '0;
    ie_full[S_TX]    = ie_q[0];
    ie_full[S_RX]    = ie_q[1];
    ie_full[S_BUS]   = ie_q[2];
    ie_full[S_BAD]   = ie_q[3];
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[C_FIXB] = fixb_q;
        reg_rdata_o[C_RUN]  = busy_i;
      end
      A_BASE:  reg_rdata_o = RW'(base_q);
      A_IE:    reg_rdata_o = ie_full;
      default: reg_rdata_o = stat_full;
    endcase
  end

  assign base_o = base_q;
  assign fixb_o = fixb_q;
  assign irq_o  = nrm | abn;
endmodule

// File: rtl/dma_walker.sv
module dma_walker
  import desc_dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int SZW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          srst_i,
  input  logic [AW-1:0] base_i,
  input  logic          dir_rx_i,
  output logic          busy_o,
  output evt_t          evt_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_valid_i,
  input  logic          mem_err_i,
  output logic          fifo_push_o,
  output logic [DW-1:0] fifo_wdata_o,
  input  logic          fifo_full_i,
  output logic          fifo_pop_o,
  input  logic [DW-1:0] fifo_rdata_i,
  input  logic          fifo_empty_i
);
  localparam int LW = SZW - 1;                       // word counter width
  localparam logic [LW-1:0] MAX_WORDS = LW'(1) << (SZW - 2);
  localparam logic [AW-1:0] DESC_STRIDE = AW'(16);
  localparam logic [AW-1:0] WORD_STEP   = AW'(4);

  walk_e         st_q;
  logic [1:0]    idx_q;
  logic          dir_q;
  logic [AW-1:0] cur_q, buf_q, nxt_q;
  logic [DW-1:0] flags_q;
  logic [LW-1:0] left_q, words;
  logic [SZW:0]  sz_up;
  logic          done, ok;

  assign sz_up = {1'b0, mem_rdata_i[SZW-1:0]} + (SZW+1)'(3);
  assign words = (mem_rdata_i[SZW-1:0] == '0) ? MAX_WORDS : sz_up[SZW:2];

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = fifo_rdata_i;
    unique case (st_q)
      W_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'({idx_q, 2'b00});
      end
      W_MOVE: begin
        mem_req_o  = dir_q ? !fifo_empty_i : !fifo_full_i;
        mem_we_o   = dir_q;
        mem_addr_o = buf_q;
      end
      W_WBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = flags_q & ~(DW'(1) << OWN_B);
      end
      default: ;
    endcase
  end

  assign done = mem_req_o && mem_valid_i;
  assign ok   = done && !mem_err_i;
  assign fifo_push_o  = (st_q == W_MOVE) && !dir_q && ok;
  assign fifo_pop_o   = (st_q == W_MOVE) && dir_q && ok;
  assign fifo_wdata_o = mem_rdata_i;
  assign busy_o       = (st_q != W_IDLE);

  assign evt_o.tx_done  = (st_q == W_WBACK) && ok && !flags_q[NOIRQ_B] && !dir_q;
  assign evt_o.rx_done  = (st_q == W_WBACK) && ok && !flags_q[NOIRQ_B] && dir_q;
  assign evt_o.bus_err  = done && mem_err_i;
  assign evt_o.bad_desc = (st_q == W_FETCH) && (idx_q == 2'd0) && ok && !mem_rdata_i[OWN_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= W_IDLE;
      idx_q   <= '0;
      dir_q   <= 1'b0;
      cur_q   <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      flags_q <= '0;
      left_q  <= '0;
    end else if (srst_i) begin
      st_q <= W_IDLE;
    end else if (done && mem_err_i) begin
      st_q <= W_IDLE;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          cur_q <= base_i;
          idx_q <= '0;
          dir_q <= dir_rx_i;
          st_q  <= W_FETCH;
        end
        W_FETCH: if (done) begin
          idx_q <= idx_q + 2'd1;
          unique case (idx_q)
            2'd0: begin
              flags_q <= mem_rdata_i;
              if (!mem_rdata_i[OWN_B]) st_q <= W_IDLE;
            end
            2'd1: left_q <= words;
            2'd2: buf_q  <= mem_rdata_i[AW-1:0];
            default: begin
              nxt_q <= mem_rdata_i[AW-1:0];
              st_q  <= W_MOVE;
            end
          endcase
        end
        W_MOVE: if (done) begin
          buf_q  <= buf_q + WORD_STEP;
          left_q <= left_q - LW'(1);
          if (left_q == LW'(1)) st_q <= W_WBACK;
        end
        W_WBACK: if (done) begin
          idx_q <= '0;
          if (flags_q[LAST_B]) st_q <= W_IDLE;
          else begin
            st_q <= W_FETCH;
            if (flags_q[CHAIN_B])     cur_q <= nxt_q;
            else if (flags_q[RING_B]) cur_q <= base_i;
            else                      cur_q <= cur_q + DESC_STRIDE;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_dma.sv
module desc_dma
  import desc_dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int SZW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          dir_rx_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_valid_i,
  input  logic          mem_err_i,
  output logic          mem_fixburst_o,
  output logic          fifo_push_o,
  output logic [DW-1:0] fifo_wdata_o,
  input  logic          fifo_full_i,
  output logic          fifo_pop_o,
  input  logic [DW-1:0] fifo_rdata_i,
  input  logic          fifo_empty_i,
  output logic          irq_o
);
  logic          busy, start, srst;
  logic [AW-1:0] base;
  evt_t          evt;

  dma_csr #(.AW(AW), .RW(32)) u_csr (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .evt_i(evt), .start_o(start), .srst_o(srst),
    .base_o(base), .fixb_o(mem_fixburst_o), .irq_o
  );

  dma_walker #(.AW(AW), .DW(DW), .SZW(SZW)) u_walk (
    .clk_i, .rst_ni, .start_i(start), .srst_i(srst), .base_i(base),
    .dir_rx_i, .busy_o(busy), .evt_o(evt),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .mem_valid_i, .mem_err_i,
    .fifo_push_o, .fifo_wdata_o, .fifo_full_i,
    .fifo_pop_o, .fifo_rdata_i, .fifo_empty_i
  );
endmodule

// File: rtl/desc_dma_chk.sv
module desc_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic          fifo_push_o,
  input logic          fifo_pop_o,
  input logic          fifo_full_i,
  input logic          fifo_empty_i
);
  logic srst_wr;
  assign srst_wr = reg_we_i && (reg_addr_i == 2'd0) && reg_wdata_i[0];

  // R4: a pending access is held with a stable address until it completes
  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i && !srst_wr) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_push_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> (mem_req_o && mem_valid_i && !mem_we_o));

  p_pop_dst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (mem_req_o && mem_valid_i && mem_we_o));

  p_no_overflow_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> !fifo_full_i);

  p_no_underflow_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);

  p_one_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_push_o && fifo_pop_o));

  p_srst_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_wr |=> !mem_req_o);
endmodule

bind desc_dma desc_dma_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i), .fifo_push_o(fifo_push_o),
  .fifo_pop_o(fifo_pop_o), .fifo_full_i(fifo_full_i), .fifo_empty_i(fifo_empty_i)
);

// File: tb/sim_desc_dma.sv
module sim_desc_dma;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 32768;
  localparam logic [31:0] F_OWN = 32'h8000_0000, F_NOIRQ = 32'h2, F_LAST = 32'h4,
                          F_FIRST = 32'h8, F_CHAIN = 32'h10, F_RING = 32'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        dir_rx = 1'b0;
  logic        mem_req, mem_we, mem_fixb, push, pop, irq;
  logic [31:0] mem_addr, mem_wdata, push_data;
  logic [31:0] m_rdata = '0;
  logic        m_valid = 1'b0, m_err = 1'b0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic        fifo_full, fifo_empty;

  logic [31:0] mem [MEMW];
  logic [31:0] txlog [20000];
  int          tx_n = 0, tx_occ = 0, tx_cap = 4;
  logic        drain = 1'b1;
  logic [31:0] rxq [256];
  int          rx_wr = 0, rx_rd = 0;

  int n_vec = 0, n_bad = 0, cyc = 0;

  desc_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dir_rx_i(dir_rx),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(m_rdata), .mem_valid_i(m_valid),
    .mem_err_i(m_err), .mem_fixburst_o(mem_fixb),
    .fifo_push_o(push), .fifo_wdata_o(push_data), .fifo_full_i(fifo_full),
    .fifo_pop_o(pop), .fifo_rdata_i(rxq[rx_rd[7:0]]), .fifo_empty_i(fifo_empty),
    .irq_o(irq)
  );

  assign fifo_full  = (tx_occ >= tx_cap);
  assign fifo_empty = (rx_rd == rx_wr);

  // memory: answers one cycle after a request
  always @(posedge clk) begin
    if (m_valid) begin
      if (mem_req && mem_we) mem[mem_addr[16:2]] = mem_wdata;
      m_valid <= 1'b0;
      m_err   <= 1'b0;
    end else if (mem_req) begin
      m_valid <= 1'b1;
      m_rdata <= mem[mem_addr[16:2]];
      m_err   <= err_en && (mem_addr == err_addr);
    end
  end

  // FIFO models
  always @(posedge clk) begin
    if (push) begin
      txlog[tx_n] <= push_data;
      tx_n <= tx_n + 1;
    end
    tx_occ <= tx_occ + (push ? 1 : 0) - ((drain && tx_occ > 0) ? 1 : 0);
    if (pop) rx_rd <= rx_rd + 1;
  end

  function automatic logic [31:0] pat(input int a);
    return 32'h5A00_0000 ^ a;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 40000; i++) begin
      reg_rd(2'd0, d);
      if (!d[2]) break;
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] fl, input int sz, input int bufa, input int nxt);
    mem[a >> 2]       = fl;
    mem[(a >> 2) + 1] = sz;
    mem[(a >> 2) + 2] = bufa;
    mem[(a >> 2) + 3] = nxt;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t0;
    for (int i = 0; i < MEMW; i++) mem[i] = pat(i * 4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_rd(2'd0, d); chk("R7 reset ctrl", d, 32'h0);
    reg_rd(2'd3, d); chk("R9 reset status", d, 32'h0);
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    chk("R1 reset req", {31'b0, mem_req}, 32'h0);

    // R1 register readback
    reg_wr(2'd1, 32'h100);
    reg_wr(2'd0, 32'h2);
    reg_rd(2'd0, d); chk("R1 fixed burst readback", d, 32'h2);
    chk("R1 fixed burst pin", {31'b0, mem_fixb}, 32'h1);
    reg_rd(2'd1, d); chk("R1 base readback", d, 32'h100);

    // linked transmit chain
    put_desc(32'h100, F_OWN | F_FIRST | F_CHAIN | F_NOIRQ, 5, 32'h1000, 32'h200);
    put_desc(32'h200, F_OWN | F_CHAIN | F_NOIRQ, 8, 32'h1100, 32'h180);
    put_desc(32'h180, F_OWN | F_CHAIN | F_LAST, 3, 32'h1200, 32'h0);
    reg_wr(2'd2, 32'h1);
    t0 = tx_n;
    reg_wr(2'd0, 32'h6);
    @(negedge clk); chk("R1 first access is word0", mem_addr, 32'h100);
    wait_idle();
    chk("R3 chain word count", tx_n - t0, 5);
    chk("R4 tx word 0", txlog[t0],   pat(32'h1000));
    chk("R4 tx word 1", txlog[t0+1], pat(32'h1004));
    chk("R6 linked word 2", txlog[t0+2], pat(32'h1100));
    chk("R6 linked word 3", txlog[t0+3], pat(32'h1104));
    chk("R6 linked word 4", txlog[t0+4], pat(32'h1200));
    chk("R5 writeback d0", mem[32'h100 >> 2], F_FIRST | F_CHAIN | F_NOIRQ);
    chk("R5 writeback d1", mem[32'h200 >> 2], F_CHAIN | F_NOIRQ);
    chk("R5 writeback d2", mem[32'h180 >> 2], F_CHAIN | F_LAST);
    reg_rd(2'd3, d); chk("R8 tx done status", d, 32'h101);
    chk("R9 irq tx", {31'b0, irq}, 32'h1);
    reg_rd(2'd0, d); chk("R7 idle after final", d, 32'h2);
    reg_wr(2'd3, 32'h0);
    reg_rd(2'd3, d); chk("R10 write zero keeps", d, 32'h101);
    reg_wr(2'd3, 32'h1);
    reg_rd(2'd3, d); chk("R10 w1c clears", d, 32'h0);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);

    // R13 transmit back-pressure
    drain = 1'b0; tx_cap = 2;
    put_desc(32'h300, F_OWN | F_LAST | F_NOIRQ, 16, 32'h1300, 0);
    reg_wr(2'd1, 32'h300);
    t0 = tx_n;
    reg_wr(2'd0, 32'h4);
    repeat (40) @(negedge clk);
    chk("R13 stalled pushes", tx_n - t0, 2);
    chk("R13 no request while full", {31'b0, mem_req}, 32'h0);
    reg_rd(2'd0, d); chk("R7 busy during run", d & 32'h4, 32'h4);
    drain = 1'b1; tx_cap = 64;
    wait_idle();
    chk("R13 resumed pushes", tx_n - t0, 4);
    chk("R4 resumed last word", txlog[t0+3], pat(32'h130C));

    // R3 size sweep
    reg_wr(2'd1, 32'h400);
    for (int s = 1; s <= 12; s++) begin
      put_desc(32'h400, F_OWN | F_LAST | F_NOIRQ, s, 32'h1400, 0);
      t0 = tx_n;
      reg_wr(2'd0, 32'h4);
      wait_idle();
      chk($sformatf("R3 size %0d words", s), tx_n - t0, (s + 3) / 4);
      chk($sformatf("R3 size %0d last", s), txlog[tx_n-1], pat(32'h1400 + 4 * ((s + 3) / 4 - 1)));
    end
    reg_rd(2'd3, d); chk("R8 suppressed completions", d, 32'h0);

    // receive, sequential descriptors, empty back-pressure
    for (int i = 0; i < 5; i++) rxq[i] = 32'hC0DE_0000 + i;
    mem[32'h3008 >> 2] = 32'hDEAD_BEEF;
    put_desc(32'h500, F_OWN | F_FIRST | F_NOIRQ, 8, 32'h3000, 32'h7777);
    put_desc(32'h510, F_OWN | F_LAST, 12, 32'h3100, 0);
    reg_wr(2'd1, 32'h500);
    reg_wr(2'd2, 32'h2);
    dir_rx = 1'b1;
    rx_wr = 1;
    reg_wr(2'd0, 32'h4);
    dir_rx = 1'b0;
    repeat (30) @(negedge clk);
    chk("R13 no request while empty", {31'b0, mem_req}, 32'h0);
    rx_wr = 5;
    wait_idle();
    chk("R4 rx word 0", mem[32'h3000 >> 2], 32'hC0DE_0000);
    chk("R4 rx word 1", mem[32'h3004 >> 2], 32'hC0DE_0001);
    chk("R3 rx bound", mem[32'h3008 >> 2], 32'hDEAD_BEEF);
    chk("R6 sequential word 0", mem[32'h3100 >> 2], 32'hC0DE_0002);
    chk("R6 sequential word 2", mem[32'h3108 >> 2], 32'hC0DE_0004);
    chk("R4 rx all popped", rx_rd, 5);
    reg_rd(2'd3, d); chk("R8 rx done status", d, 32'h102);
    reg_wr(2'd3, 32'h2);

    // wrap to base, then bad descriptor
    put_desc(32'h600, F_OWN | F_NOIRQ, 4, 32'h1000, 0);
    put_desc(32'h610, F_OWN | F_NOIRQ | F_RING, 4, 32'h1100, 0);
    reg_wr(2'd1, 32'h600);
    reg_wr(2'd2, 32'h0);
    t0 = tx_n;
    reg_wr(2'd0, 32'h4);
    wait_idle();
    chk("R6 wrap word count", tx_n - t0, 2);
    chk("R6 wrap second buffer", txlog[t0+1], pat(32'h1100));
    reg_rd(2'd3, d); chk("R2 invalid on wrap", d, 32'h30);
    chk("R9 masked irq", {31'b0, irq}, 32'h0);
    reg_wr(2'd2, 32'h10);
    reg_rd(2'd3, d); chk("R9 abnormal summary", d, 32'h230);
    chk("R9 irq abnormal", {31'b0, irq}, 32'h1);
    reg_wr(2'd3, 32'h10);
    reg_rd(2'd3, d); chk("R10 clear invalid", d, 32'h0);

    // R2 software-owned first descriptor
    put_desc(32'h700, F_LAST, 8, 32'h1000, 0);
    reg_wr(2'd1, 32'h700);
    t0 = tx_n;
    reg_wr(2'd0, 32'h4);
    wait_idle();
    chk("R2 no buffer access", tx_n - t0, 0);
    chk("R2 no writeback", mem[32'h700 >> 2], F_LAST);
    reg_rd(2'd3, d); chk("R2 status", d, 32'h230);
    reg_wr(2'd3, 32'h10);

    // R11 bus error on second buffer word
    put_desc(32'h780, F_OWN | F_LAST, 16, 32'h1200, 0);
    reg_wr(2'd1, 32'h780);
    reg_wr(2'd2, 32'h4);
    err_en = 1'b1; err_addr = 32'h1204;
    t0 = tx_n;
    reg_wr(2'd0, 32'h4);
    wait_idle();
    err_en = 1'b0;
    chk("R11 words before error", tx_n - t0, 1);
    chk("R11 no writeback", mem[32'h780 >> 2], F_OWN | F_LAST);
    reg_rd(2'd3, d); chk("R11 status", d, 32'h224);
    reg_wr(2'd3, 32'h4);

    // R8 final descriptor with completion suppressed
    put_desc(32'h7C0, F_OWN | F_LAST | F_NOIRQ, 4, 32'h1000, 0);
    reg_wr(2'd1, 32'h7C0);
    reg_wr(2'd0, 32'h4);
    wait_idle();
    reg_rd(2'd3, d); chk("R8 final suppressed", d, 32'h0);

    // R3 zero size = 65536 bytes
    put_desc(32'h800, F_OWN | F_LAST, 0, 32'h10000, 0);
    reg_wr(2'd1, 32'h800);
    t0 = tx_n;
    reg_wr(2'd0, 32'h4);
    wait_idle();
    chk("R3 zero size words", tx_n - t0, 16384);
    chk("R3 zero size first", txlog[t0], pat(32'h10000));
    chk("R3 zero size last", txlog[tx_n-1], pat(32'h1FFFC));
    reg_rd(2'd3, d); chk("R8 tx done unmasked", d, 32'h1);

    // R12 soft reset mid-run
    put_desc(32'h900, F_OWN | F_LAST, 64, 32'h1000, 0);
    reg_wr(2'd1, 32'h900);
    reg_wr(2'd2, 32'h1);
    reg_wr(2'd0, 32'h6);
    repeat (10) @(negedge clk);
    reg_wr(2'd0, 32'h1);
    chk("R12 no request", {31'b0, mem_req}, 32'h0);
    reg_rd(2'd0, d); chk("R12 ctrl cleared", d, 32'h0);
    reg_rd(2'd3, d); chk("R12 status cleared", d, 32'h0);
    reg_rd(2'd1, d); chk("R12 base kept", d, 32'h900);
    reg_rd(2'd2, d); chk("R12 enables kept", d, 32'h1);
    chk("R12 no writeback", mem[32'h900 >> 2], F_OWN | F_LAST);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule